// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address from a requester group into a physical address. Each group has a control register that turns translation on and names the address space (ASID) that the group uses. When translation is off, the address passes straight through. When it is on, the walker looks up the directory base for that ASID in a banked register file. It reads one directory entry from memory, then one table entry, and returns the physical address with the page attributes, or a fault.

Software writes the directory bases indirectly. It first stores an ASID into a select register. A write to the data register then fills the base slot of that ASID with a frame number and attribute bits. Table memory sits outside the block, behind a simple read port: the request is held until a one-cycle response arrives. The walker serves one translation at a time.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low. Every group starts with translation disabled.
- R2: For a group whose enable bit is clear, an accepted request is answered in the next cycle. The physical address equals the virtual address, the fault flag and the attributes are zero, and no memory read is made.
- R3: Writing `cfg_addr` 0 stores the ASID from bits 6:0 as the select value. Writing `cfg_addr` 1 stores, for the selected ASID, the base frame from bits PA_BITS-13:0 and the readable flag from bit 31. The directory read address is {base frame, VA[31:22], 2'b00} and the table read address is {directory frame, VA[21:12], 2'b00}. The address is held steady until the memory responds.
- R4: Writing `cfg_addr` 2+g sets group g: ASID from bits 6:0, enable from bit 31. Bits 30:7 are ignored.
- R5: On success the response carries PA = {table frame, VA[11:0]} and `rsp_attr` = {readable, writable, nonsecure}, taken from table entry bits 31, 30 and 29.
- R6: A directory entry whose bit 28 (next-level flag) is clear gives a fault after one memory read, with no table read. Every faulting response carries a PA of zero and attributes of zero.
- R7: A table entry that has neither bit 31 nor bit 30 set gives a fault.
- R8: A write request (`req_write`=1) to an entry with bit 30 clear faults. A read request to an entry with bit 31 clear faults.
- R9: `req_ready` is low from the cycle after acceptance through the response cycle. `rsp_valid` is high for exactly one cycle: the cycle after the last memory response, or the cycle after acceptance if no memory read is needed. `req_ready` is high again in the cycle after that.
- R10: Only the low PA_BITS-12 bits of an entry are taken as the frame number. Entry bits 27 down to PA_BITS-12 have no effect.
- R11: If the directory base of the selected ASID has its readable bit clear, the response is a fault in the cycle after acceptance, and no memory read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index: 0 select, 1 base data, 2+g group g |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_grp | input | GRP_W | Requester group |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_pa | output | PA_BITS | Physical address |
| rsp_attr | output | 3 | {readable, writable, nonsecure} |
| mem_req_valid | output | 1 | Table read request, held until response |
| mem_req_addr | output | PA_BITS | Table read byte address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Read data |

## Verification
A stale or wrongly indexed base slot, or a group register holding the wrong ASID, is visible at the memory port. It appears on the first directory read address, one cycle after the request is accepted. A frame latched from the wrong entry shows up on the table read address or in the response PA. A state machine stuck in the wrong phase shows up as a response that comes early or late, an extra or missing memory read, or `req_ready` rising before the response pulse. Each of these is visible within the same translation.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   localparam int VA_BITS    = 32;
   localparam int PAGE_SHIFT = 12;
   localparam int IDX_BITS   = 10;
   localparam int ASID_W     = 7;
   localparam int ENT_RD     = 31;
   localparam int ENT_WR     = 30;
   localparam int ENT_NS     = 29;
   localparam int ENT_NEXT   = 28;
   localparam int GRP_EN     = 31;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_DIR  = 2'd1,
      WS_TBL  = 2'd2,
      WS_RESP = 2'd3
   } walk_state_t;

   function automatic logic leaf_fault(input logic [31:0] ent, input logic is_wr);
      logic rd_ok, wr_ok;
      rd_ok = ent[ENT_RD];
      wr_ok = ent[ENT_WR];
      return !(rd_ok || wr_ok) || (is_wr && !wr_ok) || (!is_wr && !rd_ok);
   endfunction
endpackage

// File: rtl/pgwalk_base_bank.sv
module pgwalk_base_bank
   import pgwalk_pkg::*;
#(
   parameter int NUM_ASID = 128,
   parameter int PFN_W    = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic              data_we,
   input  logic [31:0]       wdata,
   input  logic [ASID_W-1:0] rd_asid,
   output logic [PFN_W-1:0]  rd_pfn,
   output logic              rd_ok
);
   logic [ASID_W-1:0] sel_q;
   logic [PFN_W-1:0]  pfn_q [NUM_ASID];
   logic [NUM_ASID-1:0] ok_q;
   logic wdata_unused;

   assign wdata_unused = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (sel_we) begin
         sel_q <= wdata[ASID_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q <= '0;
         for (int i = 0; i < NUM_ASID; i++) pfn_q[i] <= '0;
      end else if (data_we) begin
         for (int i = 0; i < NUM_ASID; i++) begin
            if (sel_q == ASID_W'(i)) begin
               pfn_q[i] <= wdata[PFN_W-1:0];
               ok_q[i]  <= wdata[ENT_RD];
            end
         end
      end
   end

   always_comb begin
      rd_pfn = '0;
      rd_ok  = 1'b0;
      for (int i = 0; i < NUM_ASID; i++) begin
         if (rd_asid == ASID_W'(i)) begin
            rd_pfn = pfn_q[i];
            rd_ok  = ok_q[i];
         end
      end
   end
endmodule

// File: rtl/pgwalk_grp_regs.sv
module pgwalk_grp_regs
   import pgwalk_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] we,
   input  logic [31:0]           wdata,
   input  logic [GRP_W-1:0]      rd_grp,
   output logic                  rd_en,
   output logic [ASID_W-1:0]     rd_asid
);
   logic [NUM_GROUPS-1:0]             en_vec;
   logic [NUM_GROUPS-1:0][ASID_W-1:0] asid_vec;
   logic wdata_unused;

   assign wdata_unused = ^wdata;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic              en_q;
      logic [ASID_W-1:0] asid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            asid_q <= '0;
         end else if (we[g]) begin
            en_q   <= wdata[GRP_EN];
            asid_q <= wdata[ASID_W-1:0];
         end
      end

      assign en_vec[g]   = en_q;
      assign asid_vec[g] = asid_q;
   end

   always_comb begin
      rd_en   = 1'b0;
      rd_asid = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (rd_grp == GRP_W'(g)) begin
            rd_en   = en_vec[g];
            rd_asid = asid_vec[g];
         end
      end
   end
endmodule

// File: rtl/pgwalk_walker.sv
module pgwalk_walker
   import pgwalk_pkg::*;
#(
   parameter int PA_BITS = 32,
   localparam int PFN_W = PA_BITS - PAGE_SHIFT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [31:0]        req_va,
   input  logic               req_write,
   input  logic               xl_en,
   input  logic               base_ok,
   input  logic [PFN_W-1:0]   base_pfn,
   output logic               mem_req_valid,
   output logic [PA_BITS-1:0] mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [31:0]        mem_rsp_data,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [PA_BITS-1:0] rsp_pa,
   output logic [2:0]         rsp_attr
);
   walk_state_t        state_q;
   logic [31:0]        va_q;
   logic               wr_q;
   logic [PFN_W-1:0]   frame_q;
   logic               fault_q;
   logic [PA_BITS-1:0] pa_q;
   logic [2:0]         attr_q;
   logic [PA_BITS-1:0] bypass_pa;
   logic [IDX_BITS-1:0] cur_idx;
   logic               accept;
   logic               data_unused;

   assign data_unused = ^mem_rsp_data;

   if (PA_BITS > VA_BITS) begin : g_zext
      assign bypass_pa = {{(PA_BITS-VA_BITS){1'b0}}, req_va};
   end else begin : g_trunc
      assign bypass_pa = req_va[PA_BITS-1:0];
   end

   assign accept        = req_valid && (state_q == WS_IDLE);
   assign req_ready     = (state_q == WS_IDLE);
   assign mem_req_valid = (state_q == WS_DIR) || (state_q == WS_TBL);
   assign cur_idx       = (state_q == WS_DIR) ? va_q[31:22] : va_q[21:12];
   assign mem_req_addr  = {frame_q, cur_idx, 2'b00};
   assign rsp_valid     = (state_q == WS_RESP);
   assign rsp_fault     = fault_q;
   assign rsp_pa        = pa_q;
   assign rsp_attr      = attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         frame_q <= '0;
         fault_q <= 1'b0;
         pa_q    <= '0;
         attr_q  <= '0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (accept) begin
                  va_q    <= req_va;
                  wr_q    <= req_write;
                  fault_q <= 1'b0;
                  pa_q    <= '0;
                  attr_q  <= '0;
                  if (!xl_en) begin
                     pa_q    <= bypass_pa;
                     state_q <= WS_RESP;
                  end else if (!base_ok) begin
                     fault_q <= 1'b1;
                     state_q <= WS_RESP;
                  end else begin
                     frame_q <= base_pfn;
                     state_q <= WS_DIR;
                  end
               end
            end
            WS_DIR: begin
               if (mem_rsp_valid) begin
                  if (!mem_rsp_data[ENT_NEXT]) begin
                     fault_q <= 1'b1;
                     state_q <= WS_RESP;
                  end else begin
                     frame_q <= mem_rsp_data[PFN_W-1:0];
                     state_q <= WS_TBL;
                  end
               end
            end
            WS_TBL: begin
               if (mem_rsp_valid) begin
                  if (leaf_fault(mem_rsp_data, wr_q)) begin
                     fault_q <= 1'b1;
                  end else begin
                     pa_q   <= {mem_rsp_data[PFN_W-1:0], va_q[PAGE_SHIFT-1:0]};
                     attr_q <= mem_rsp_data[ENT_RD:ENT_NS];
                  end
                  state_q <= WS_RESP;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   // R9
   busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);
   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   // R6
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_attr == 3'b000));
   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
   // R3
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
   // R2
   bypass_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !xl_en) |=> (rsp_valid && !rsp_fault));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int PA_BITS    = 32,
   parameter int NUM_ASID   = 128,
   parameter int NUM_GROUPS = 4,
   localparam int PFN_W  = PA_BITS - PAGE_SHIFT,
   localparam int CFG_AW = $clog2(NUM_GROUPS + 2),
   localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic [31:0]        cfg_wdata,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [GRP_W-1:0]   req_grp,
   input  logic [31:0]        req_va,
   input  logic               req_write,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [PA_BITS-1:0] rsp_pa,
   output logic [2:0]         rsp_attr,
   output logic               mem_req_valid,
   output logic [PA_BITS-1:0] mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [31:0]        mem_rsp_data
);
   if (PA_BITS < 24 || PA_BITS > 40) begin : g_bad_pa
      $error("pgwalk_top: PA_BITS must lie in 24..40 so the frame stays below the flag bits");
   end
   if (NUM_ASID < 1 || NUM_ASID > (1 << ASID_W)) begin : g_bad_asid
      $error("pgwalk_top: NUM_ASID out of range");
   end
   if (NUM_GROUPS < 1) begin : g_bad_grp
      $error("pgwalk_top: NUM_GROUPS must be at least 1");
   end

   logic                  sel_we, data_we;
   logic [NUM_GROUPS-1:0] grp_we;
   logic                  grp_en;
   logic [ASID_W-1:0]     grp_asid;
   logic [PFN_W-1:0]      base_pfn;
   logic                  base_ok;

   assign sel_we  = cfg_we && (cfg_addr == CFG_AW'(0));
   assign data_we = cfg_we && (cfg_addr == CFG_AW'(1));

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
      assign grp_we[g] = cfg_we && (cfg_addr == CFG_AW'(g + 2));
   end

   pgwalk_grp_regs #(.NUM_GROUPS(NUM_GROUPS)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (grp_we),
      .wdata   (cfg_wdata),
      .rd_grp  (req_grp),
      .rd_en   (grp_en),
      .rd_asid (grp_asid)
   );

   pgwalk_base_bank #(.NUM_ASID(NUM_ASID), .PFN_W(PFN_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_we  (sel_we),
      .data_we (data_we),
      .wdata   (cfg_wdata),
      .rd_asid (grp_asid),
      .rd_pfn  (base_pfn),
      .rd_ok   (base_ok)
   );

   pgwalk_walker #(.PA_BITS(PA_BITS)) u_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_va        (req_va),
      .req_write     (req_write),
      .xl_en         (grp_en),
      .base_ok       (base_ok),
      .base_pfn      (base_pfn),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_fault     (rsp_fault),
      .rsp_pa        (rsp_pa),
      .rsp_attr      (rsp_attr)
   );

   // R1
   idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_req_valid));
endmodule

// File: tb/pgwalk_tb_top.sv
module pgwalk_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic        req_ready;
   logic [1:0]  req_grp;
   logic [31:0] req_va;
   logic        req_write;
   logic        rsp_valid, rsp_fault;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_attr;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   always #5 clk = ~clk;

   pgwalk_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_grp(req_grp), .req_va(req_va),
      .req_write(req_write), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .rsp_attr(rsp_attr), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   int n_reads = 0;
   logic [31:0] rd_log [8];
   logic [31:0] mem [logic [31:0]];

   bit          g_en   [4];
   logic [6:0]  g_asid [4];
   logic [19:0] b_pfn  [128];
   bit          b_rd   [128];
   logic [9:0]  dsel [2][6];
   logic [9:0]  tsel [2][6][6];

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model with 0..2 cycles of latency
   initial begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         logic [31:0] a;
         int lat;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid === 1'b1) begin
            a = mem_req_addr;
            rd_log[n_reads % 8] = a;
            n_reads++;
            lat = $urandom % 3;
            repeat (lat) @(negedge clk);
            mem_rsp_data  = rd(a);
            mem_rsp_valid = 1'b1;
         end
      end
   end

   function automatic void model(input int g, input logic [31:0] va, input bit wr,
                                 output bit f, output logic [31:0] pa, output logic [2:0] at,
                                 output int n, output logic [31:0] a0, output logic [31:0] a1);
      logic [6:0]  as;
      logic [31:0] d, t;
      f = 0; pa = '0; at = '0; n = 0; a0 = '0; a1 = '0;
      if (!g_en[g]) begin pa = va; return; end
      as = g_asid[g];
      if (!b_rd[as]) begin f = 1; return; end
      a0 = {b_pfn[as], va[31:22], 2'b00};
      d = rd(a0); n = 1;
      if (!d[28]) begin f = 1; return; end
      a1 = {d[19:0], va[21:12], 2'b00};
      t = rd(a1); n = 2;
      if (wr ? !t[30] : !t[31]) begin f = 1; return; end
      pa = {t[19:0], va[11:0]};
      at = t[31:29];
   endfunction

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_base(input logic [6:0] as, input logic [19:0] pfn, input bit rdok);
      cfg_write(3'd0, {25'h1ABCDE, as});
      cfg_write(3'd1, {rdok, 2'b11, 9'h0, pfn});
      b_pfn[as] = pfn;
      b_rd[as]  = rdok;
   endtask

   task automatic set_grp(input int g, input bit en, input logic [6:0] as);
      cfg_write(3'(g + 2), {en, 24'hA5C35A, as});
      g_en[g]   = en;
      g_asid[g] = as;
   endtask

   task automatic xlate(input int g, input logic [31:0] va, input bit wr, input string req);
      bit e_f; logic [31:0] e_pa; logic [2:0] e_at; int e_n;
      logic [31:0] e_a0, e_a1;
      int base_n, cyc;
      bit busy_ok;
      model(g, va, wr, e_f, e_pa, e_at, e_n, e_a0, e_a1);
      @(negedge clk);
      chk(req_ready === 1'b1, "R9", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_grp = 2'(g); req_va = va; req_write = wr;
      base_n = n_reads;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1; busy_ok = 1;
      while (rsp_valid !== 1'b1 && cyc < 60) begin
         if (req_ready !== 1'b0) busy_ok = 0;
         @(negedge clk);
         cyc++;
      end
      if (req_ready !== 1'b0) busy_ok = 0;
      chk(rsp_valid === 1'b1, "R9", "response arrives", rsp_valid, 1);
      chk(busy_ok, "R9", "ready low while busy", req_ready, 0);
      chk(rsp_fault === e_f, req, "fault", rsp_fault, e_f);
      chk(rsp_pa === e_pa, req, "pa", rsp_pa, e_pa);
      chk(rsp_attr === e_at, req, "attr", rsp_attr, e_at);
      chk(n_reads - base_n == e_n, req, "memory reads", n_reads - base_n, e_n);
      if (e_n >= 1) chk(rd_log[base_n % 8] === e_a0, "R3", "directory address", rd_log[base_n % 8], e_a0);
      if (e_n >= 2) chk(rd_log[(base_n + 1) % 8] === e_a1, "R3", "table address", rd_log[(base_n + 1) % 8], e_a1);
      if (e_n == 0) chk(cyc == 1, "R9", "latency without reads", cyc, 1);
      @(negedge clk);
      chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9", "single pulse then ready",
          {rsp_valid, req_ready}, 2'b01);
   endtask

   function automatic logic [31:0] rnd_ent(input bit next);
      logic [31:0] r;
      r = $urandom;
      r[28] = next;
      return r;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_grp = '0; req_va = '0; req_write = 1'b0;
      for (int i = 0; i < 4; i++) begin g_en[i] = 0; g_asid[i] = '0; end
      for (int i = 0; i < 128; i++) begin b_pfn[i] = '0; b_rd[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
          "reset outputs", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
          "after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

      // R1 / R2: all groups disabled at reset, pass through
      xlate(0, 32'hDEADBEEF, 1'b0, "R2");
      xlate(3, 32'h00000000, 1'b1, "R2");

      // directed table contents for ASID 5
      set_base(7'd5, 20'h00105, 1'b1);
      mem[{20'h00105, 10'd3, 2'b00}]    = 32'h9000_0000 | 32'h0001_0050;   // next, readable
      mem[{20'h00105, 10'd4, 2'b00}]    = 32'hC000_0000 | 32'h0001_0060;   // no next flag
      mem[{20'h00105, 10'd1023, 2'b00}] = 32'h1000_0000 | 32'h0001_0070;   // next, no attrs
      mem[{20'h10050, 10'd9, 2'b00}]    = 32'hE000_0000 | 32'h0AB0_0000 | 32'h000C_AFE5;
      mem[{20'h10050, 10'd10, 2'b00}]   = 32'h8000_0000 | 32'h0000_1234;   // read only
      mem[{20'h10050, 10'd11, 2'b00}]   = 32'h4000_0000 | 32'h0000_5678;   // write only
      mem[{20'h10050, 10'd12, 2'b00}]   = 32'h2000_0000 | 32'h0000_9ABC;   // neither
      mem[{20'h10070, 10'd1023, 2'b00}] = 32'hA000_0000 | 32'h0FF0_0000 | 32'h000F_FFFF;

      // R4: enable clear with ASID set still passes through
      set_grp(1, 1'b0, 7'd5);
      xlate(1, {10'd3, 10'd9, 12'h123}, 1'b0, "R4");
      set_grp(0, 1'b1, 7'd5);
      set_grp(1, 1'b1, 7'd5);
      // R5 R10: success with junk bits above the frame
      xlate(0, {10'd3, 10'd9, 12'h123}, 1'b0, "R5");
      xlate(1, {10'd3, 10'd9, 12'hFFF}, 1'b1, "R10");
      // R8
      xlate(0, {10'd3, 10'd10, 12'h001}, 1'b1, "R8");
      xlate(0, {10'd3, 10'd10, 12'h002}, 1'b0, "R5");
      xlate(0, {10'd3, 10'd11, 12'h003}, 1'b0, "R8");
      xlate(0, {10'd3, 10'd11, 12'h004}, 1'b1, "R5");
      // R7
      xlate(0, {10'd3, 10'd12, 12'h005}, 1'b0, "R7");
      xlate(0, {10'd3, 10'd12, 12'h006}, 1'b1, "R7");
      // R6: no next flag, and an empty directory slot
      xlate(0, {10'd4, 10'd9, 12'h007}, 1'b0, "R6");
      xlate(0, 32'h0000_0000, 1'b0, "R6");
      // boundary: top directory and table indices
      xlate(0, 32'hFFFF_FFFF, 1'b0, "R5");
      // R11: base without readable bit
      set_base(7'd0, 20'h00100, 1'b0);
      set_grp(3, 1'b1, 7'd0);
      xlate(3, {10'd3, 10'd9, 12'h0}, 1'b0, "R11");

      // random tables for ASIDs 77 and 127
      for (int s = 0; s < 2; s++) begin
         logic [6:0] as;
         as = (s == 0) ? 7'd77 : 7'd127;
         set_base(as, 20'h00100 + 20'(as), 1'b1);
         for (int k = 0; k < 6; k++) begin
            logic [19:0] tp;
            dsel[s][k] = 10'($urandom);
            tp = 20'h20000 + 20'(s * 64 + k);
            mem[{20'h00100 + 20'(as), dsel[s][k], 2'b00}] =
               {rnd_ent(($urandom % 8) != 0) & 32'hFFF0_0000} | {12'h0, tp};
            for (int j = 0; j < 6; j++) begin
               tsel[s][k][j] = 10'($urandom);
               mem[{tp, tsel[s][k][j], 2'b00}] = rnd_ent(1'($urandom));
            end
         end
      end
      set_grp(1, 1'b1, 7'd77);
      set_grp(2, 1'b1, 7'd127);

      for (int it = 0; it < 300; it++) begin
         int g, s, k, j;
         logic [31:0] va;
         g = $urandom % 4;
         va = $urandom;
         if (g == 1 || g == 2) begin
            s = g - 1; k = $urandom % 6; j = $urandom % 6;
            if (($urandom % 4) != 0) va = {dsel[s][k], tsel[s][k][j], va[11:0]};
         end else if (g == 0 && ($urandom % 2) == 0) begin
            va = {10'd3, 10'd9 + 10'($urandom % 4), va[11:0]};
         end
         if (it == 150) set_grp(3, 1'b0, 7'd0);
         xlate(g, va, 1'($urandom), "R5");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule